// File: doc/BRIEF.md
# Parent-Controlled Periodic Timer

This block is a periodic up-counter driven through a prescaler, with an auto-reload limit and a repetition down-counter. It raises a one-cycle output trigger on every update event. An update event occurs once per (N+1) counter wraps, where N is the repetition setting. A second signal, the parent trigger, arrives without any timing relation to the clock. A 3-bit mode field selects how that signal acts on the counter. It can have no effect, or it can restart the counter, gate it, start it, or act as its count clock.

The prescaler, auto-reload and repetition values are written into preload inputs. The counter copies them into working copies only on an update event. An update event is a repetition expiry or a restart from the parent. A write to a preload input therefore never disturbs a period that is already in progress.

Top module: `ptrig_timer`

## Requirements
- R1: While `rst_n` is low and after its release, `count` is 0 and `trig_out` is 0. The working prescaler, limit and repetition values are all 0 after reset, so the first count tick produces an update event that loads the preload values.
- R2: Mode code 0 is free-running: with `en` high the counter ticks on every clock and `par_trig` has no effect. Codes 1, 2 and 3 behave exactly like code 0.
- R3: The counter advances once every (PSC+1) count ticks. When it advances from the working limit ARR, it returns to 0, so `count` never exceeds the working ARR.
- R4: An update event occurs on every (N+1)-th wrap, where N is the working repetition value. After each update, the repetition counter reloads with `rep_pre`.
- R5: `trig_out` is high for exactly the one cycle after each update event, and `count` is 0 in that cycle.
- R6: Changes to `psc_pre`, `arr_pre` and `rep_pre` take effect only at the next update event.
- R7: In mode 4, each synchronised rising edge of `par_trig` forces `count` and the prescaler to 0 and forces an update event (with `trig_out` and a preload reload). Between edges the counter runs as in mode 0.
- R8: In mode 5, the counter ticks only while the synchronised `par_trig` is high. When it is low, `count` holds its value and is not cleared.
- R9: In mode 6, the counter does not tick until a synchronised rising edge of `par_trig`. From then on it runs freely without being cleared, whatever level `par_trig` later has, until `en` drops or the mode changes.
- R10: In mode 7, each synchronised rising edge of `par_trig` is one count tick, and nothing else is. `par_trig` passes through two synchroniser flops, so an edge acts on the third clock edge after it is applied.
- R11: While `en` is low, `count` holds and `trig_out` stays low in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counter enable |
| par_trig | input | 1 | Parent trigger, asynchronous |
| mode | input | 3 | Parent mode: 0 free, 1-3 as 0, 4 restart, 5 gate, 6 start, 7 external clock |
| psc_pre | input | PSC_W | Prescaler preload (divide by value+1) |
| arr_pre | input | CNT_W | Auto-reload limit preload |
| rep_pre | input | REP_W | Repetition preload (update every value+1 wraps) |
| count | output | CNT_W | Current counter value |
| trig_out | output | 1 | One-cycle pulse per update event |

## Verification
The properties take `mode` as steady for at least one cycle around each edge they judge. They relate the synchronised parent level and its edge, not the raw pin, to the counter one cycle later. They also assume that `par_trig` pulses last at least one clock in each phase, so that every edge is seen. The stimulus changes `mode` and the preloads only during reset or with `en` low, except for the one deliberate mid-period write to `arr_pre`. It holds each parent level for at least one full clock period, with its changes made on the falling clock edge.

// File: rtl/ptrig_pkg.sv
package ptrig_pkg;

    typedef enum logic [2:0] {
        MD_FREE    = 3'd0,
        MD_QUAD_A  = 3'd1,
        MD_QUAD_B  = 3'd2,
        MD_QUAD_C  = 3'd3,
        MD_RESTART = 3'd4,
        MD_GATE    = 3'd5,
        MD_START   = 3'd6,
        MD_EXTCLK  = 3'd7
    } par_mode_e;

    // Quadrature codes are not implemented here: they fold onto free running.
    function automatic par_mode_e fold_mode(input logic [2:0] raw);
        par_mode_e m;
        case (raw)
            3'd4:    m = MD_RESTART;
            3'd5:    m = MD_GATE;
            3'd6:    m = MD_START;
            3'd7:    m = MD_EXTCLK;
            default: m = MD_FREE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ptrig_sync.sv
module ptrig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl,
    output logic rise
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign lvl  = sh_q[STAGES-1];
    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ptrig_tick_sel.sv
module ptrig_tick_sel
    import ptrig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [2:0] mode_raw,
    input  logic       lvl,
    input  logic       rise,
    output logic       tick,
    output logic       reinit
);
    typedef struct packed {
        logic run;
    } sel_state_t;

    sel_state_t d, q;
    par_mode_e  md;

    assign md = fold_mode(mode_raw);

    always_comb begin
        d      = q;
        d.run  = 1'b0;
        tick   = 1'b0;
        reinit = 1'b0;
        case (md)
            MD_RESTART: begin
                tick   = en;
                reinit = en & rise;
            end
            MD_GATE: begin
                tick = en & lvl;
            end
            MD_START: begin
                d.run = en & (q.run | rise);
                tick  = en & q.run;
            end
            MD_EXTCLK: begin
                tick = en & rise;
            end
            default: begin
                tick = en;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ptrig_core.sv
module ptrig_core #(
    parameter int PSC_W = 16,
    parameter int CNT_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reinit,
    input  logic [PSC_W-1:0] psc_pre,
    input  logic [CNT_W-1:0] arr_pre,
    input  logic [REP_W-1:0] rep_pre,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] arr_act,
    output logic             pulse
);
    localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [REP_W-1:0] REP_ONE = REP_W'(1);

    typedef struct packed {
        logic [PSC_W-1:0] psc_cnt;
        logic [PSC_W-1:0] psc_sh;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] arr_sh;
        logic [REP_W-1:0] rep_cnt;
        logic             pulse;
    } core_state_t;

    core_state_t d, q;
    logic        upd;

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        upd     = 1'b0;
        if (reinit) begin
            d.psc_cnt = '0;
            d.cnt     = '0;
            upd       = 1'b1;
        end else if (tick) begin
            if (q.psc_cnt == q.psc_sh) begin
                d.psc_cnt = '0;
                if (q.cnt == q.arr_sh) begin
                    d.cnt = '0;
                    if (q.rep_cnt == '0) upd = 1'b1;
                    else                 d.rep_cnt = q.rep_cnt - REP_ONE;
                end else begin
                    d.cnt = q.cnt + CNT_ONE;
                end
            end else begin
                d.psc_cnt = q.psc_cnt + PSC_ONE;
            end
        end
        if (upd) begin
            d.psc_sh  = psc_pre;
            d.arr_sh  = arr_pre;
            d.rep_cnt = rep_pre;
            d.pulse   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt     = q.cnt;
    assign arr_act = q.arr_sh;
    assign pulse   = q.pulse;
endmodule

// File: rtl/ptrig_timer.sv
module ptrig_timer #(
    parameter int PSC_W       = 16,
    parameter int CNT_W       = 16,
    parameter int REP_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             par_trig,
    input  logic [2:0]       mode,
    input  logic [PSC_W-1:0] psc_pre,
    input  logic [CNT_W-1:0] arr_pre,
    input  logic [REP_W-1:0] rep_pre,
    output logic [CNT_W-1:0] count,
    output logic             trig_out
);
    logic             par_lvl, par_rise;
    logic             tick, reinit;
    logic [CNT_W-1:0] arr_act;

    ptrig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (par_trig),
        .lvl      (par_lvl),
        .rise     (par_rise)
    );

    ptrig_tick_sel u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .mode_raw (mode),
        .lvl      (par_lvl),
        .rise     (par_rise),
        .tick     (tick),
        .reinit   (reinit)
    );

    ptrig_core #(.PSC_W(PSC_W), .CNT_W(CNT_W), .REP_W(REP_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .reinit  (reinit),
        .psc_pre (psc_pre),
        .arr_pre (arr_pre),
        .rep_pre (rep_pre),
        .cnt     (count),
        .arr_act (arr_act),
        .pulse   (trig_out)
    );
endmodule

// File: rtl/ptrig_timer_chk.sv
module ptrig_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [2:0]       mode,
    input logic             par_lvl,
    input logic             par_rise,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] arr_act,
    input logic             trig_out
);
    a_r3_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        count <= arr_act);

    a_r5_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> (count == '0));

    a_r7_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && en && par_rise) |=> (count == '0 && trig_out));

    a_r8_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5 && !par_lvl) |=> $stable(count));

    a_r10_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd7 && !par_rise) |=> ($stable(count) && !trig_out));

    a_r11_idle_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(count) && !trig_out));
endmodule

bind ptrig_timer ptrig_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .mode     (mode),
    .par_lvl  (par_lvl),
    .par_rise (par_rise),
    .count    (count),
    .arr_act  (arr_act),
    .trig_out (trig_out)
);

// File: tb/ptrig_timer_test.sv
module ptrig_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int PSC_W = 16;
    localparam int CNT_W = 16;
    localparam int REP_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             par_trig = 1'b0;
    logic [2:0]       mode = 3'd0;
    logic [PSC_W-1:0] psc_pre = '0;
    logic [CNT_W-1:0] arr_pre = '0;
    logic [REP_W-1:0] rep_pre = '0;
    logic [CNT_W-1:0] count;
    logic             trig_out;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptrig_timer #(.PSC_W(PSC_W), .CNT_W(CNT_W), .REP_W(REP_W)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .par_trig(par_trig), .mode(mode),
        .psc_pre(psc_pre), .arr_pre(arr_pre), .rep_pre(rep_pre),
        .count(count), .trig_out(trig_out)
    );

    typedef struct packed {
        logic [2:0]  md;
        logic        trg;
        logic [7:0]  psc;
        logic [7:0]  arr;
        logic [7:0]  rep;
        logic [15:0] ticks;
        logic [7:0]  exp_upd;
        logic [15:0] exp_cnt;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 8'd0, 8'd3, 8'd0, 16'd10, 8'd3, 16'd1},  // R2 R3
        '{3'd0, 1'b0, 8'd1, 8'd2, 8'd0, 16'd14, 8'd3, 16'd0},  // R3 prescale
        '{3'd0, 1'b0, 8'd0, 8'd1, 8'd2, 16'd13, 8'd3, 16'd0},  // R4 repetition
        '{3'd0, 1'b0, 8'd2, 8'd4, 8'd1, 16'd20, 8'd1, 16'd1},  // R3 R4
        '{3'd3, 1'b1, 8'd0, 8'd2, 8'd0, 16'd7,  8'd3, 16'd0},  // R2 quad code
        '{3'd5, 1'b1, 8'd0, 8'd3, 8'd0, 16'd10, 8'd3, 16'd1},  // R8 gate open
        '{3'd5, 1'b0, 8'd0, 8'd3, 8'd0, 16'd10, 8'd0, 16'd0},  // R8 gate shut
        '{3'd6, 1'b0, 8'd0, 8'd3, 8'd0, 16'd10, 8'd0, 16'd0},  // R9 no start
        '{3'd7, 1'b1, 8'd0, 8'd3, 8'd0, 16'd10, 8'd0, 16'd0},  // R10 no edge
        '{3'd4, 1'b0, 8'd0, 8'd3, 8'd0, 16'd10, 8'd3, 16'd1}   // R7 no edge
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_edges(input int n, input bit toggle, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (trig_out) pulses++;
            if (toggle) par_trig = ~par_trig;
        end
    endtask

    task automatic do_reset(input logic t, input logic [2:0] m,
                            input int psc, input int arr, input int rep);
        int p;
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0; par_trig = t; mode = m;
        psc_pre = PSC_W'(psc); arr_pre = CNT_W'(arr); rep_pre = REP_W'(rep);
        run_edges(2, 1'b0, p);
        rst_n = 1'b1;
        run_edges(3, 1'b0, p);
        chk("R1 idle pulses", p, 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int p;
        // R1: reset state
        @(negedge clk);
        chk("R1 count in reset", int'(count), 0);
        chk("R1 trig_out in reset", int'(trig_out), 0);
        rst_n = 1'b1;
        run_edges(2, 1'b0, p);
        chk("R1 count after release", int'(count), 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            do_reset(VECS[v].trg, VECS[v].md, int'(VECS[v].psc),
                     int'(VECS[v].arr), int'(VECS[v].rep));
            en = 1'b1;
            run_edges(int'(VECS[v].ticks), 1'b0, p);
            en = 1'b0;
            chk($sformatf("R2-table vector %0d updates (R3 R4 R8 R9 R10)", v),
                p, int'(VECS[v].exp_upd));
            chk($sformatf("vector %0d count (R3)", v),
                int'(count), int'(VECS[v].exp_cnt));
        end

        // R2: free running ignores a toggling parent; R11 hold
        do_reset(1'b0, 3'd0, 0, 3, 0);
        en = 1'b1;
        run_edges(10, 1'b1, p);
        en = 1'b0;
        chk("R2 toggling parent updates", p, 3);
        chk("R2 toggling parent count", int'(count), 1);
        run_edges(5, 1'b1, p);
        chk("R11 enable low pulses", p, 0);
        chk("R11 enable low count", int'(count), 1);

        // R7 restart, R6 preload timing, R5 single-cycle pulse
        do_reset(1'b0, 3'd4, 0, 15, 0);
        en = 1'b1;
        run_edges(10, 1'b0, p);
        chk("R7 count before edge", int'(count), 9);
        par_trig = 1'b1;
        arr_pre = CNT_W'(2);
        run_edges(2, 1'b0, p);
        chk("R6 preload not applied mid-period", int'(count), 11);
        run_edges(1, 1'b0, p);
        chk("R7 restart clears count", int'(count), 0);
        chk("R7 restart raises trig_out", int'(trig_out), 1);
        run_edges(1, 1'b0, p);
        chk("R5 trig_out single cycle", int'(trig_out), 0);
        chk("R7 count after restart", int'(count), 1);
        run_edges(2, 1'b0, p);
        chk("R6 new limit wraps", int'(count), 0);
        chk("R6 update at new limit", p, 1);
        en = 1'b0;

        // R9 start
        do_reset(1'b0, 3'd6, 0, 15, 0);
        en = 1'b1;
        run_edges(5, 1'b0, p);
        chk("R9 waits for edge count", int'(count), 0);
        chk("R9 waits for edge pulses", p, 0);
        par_trig = 1'b1;
        run_edges(10, 1'b0, p);
        chk("R9 started count", int'(count), 6);
        par_trig = 1'b0;
        run_edges(4, 1'b0, p);
        chk("R9 keeps running after parent low", int'(count), 10);
        en = 1'b0;

        // R8 gate holds its value
        do_reset(1'b1, 3'd5, 0, 15, 0);
        en = 1'b1;
        run_edges(6, 1'b0, p);
        chk("R8 gated count open", int'(count), 5);
        par_trig = 1'b0;
        run_edges(8, 1'b0, p);
        chk("R8 gate closed after sync delay", int'(count), 7);
        run_edges(4, 1'b0, p);
        chk("R8 gate holds value", int'(count), 7);
        en = 1'b0;

        // R10 external clock
        do_reset(1'b0, 3'd7, 0, 15, 0);
        en = 1'b1;
        for (int k = 0; k < 5; k++) begin
            par_trig = 1'b1;
            run_edges(3, 1'b0, p);
            par_trig = 1'b0;
            run_edges(3, 1'b0, p);
        end
        run_edges(4, 1'b0, p);
        chk("R10 one tick per parent edge", int'(count), 4);
        en = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule